// File: doc/BRIEF.md
# Phase-Accumulator Sine Synthesizer Core

This core generates a digital sine wave from one sample clock. Each cycle it adds a 48-bit tuning word to a running 48-bit phase. A 16-bit phase offset, aligned to the top of the phase, is added to that phase. The upper 19 bits of the sum are registered as the angle. A pipelined CORDIC rotator turns the angle into a 14-bit offset-binary amplitude that feeds a DAC. The output frequency is the tuning word times the sample rate divided by 2^48.

Software loads the tuning word and the offset a byte at a time into shadow registers. A one-cycle update pulse copies both shadows into the active registers together, so a retune takes effect on a known edge. Retuning never clears the accumulator, so the phase stays continuous. A synchronous core reset clears the accumulator and the conversion pipeline but keeps the programmed words. A full reset also clears the shadow and active registers.

Top module: `dds_core`

## Requirements
- R1: On every clock edge outside reset, the 48-bit accumulator adds the active tuning word and wraps modulo 2^48. The accumulator starts at zero after either reset.
- R2: The active 16-bit offset is added to the accumulator with its LSB at accumulator bit 32, before truncation.
- R3: `angle` shows bits [47:29] of (accumulator + offset). The accumulator value used is the one held before the edge that updates `angle`.
- R4: `amp` equals 0x2000 + round(8191·sin(2π·a/2^19)) within ±2 LSB. Here `a` is the value `angle` showed 20 cycles earlier, so the converter latency is 20 cycles.
- R5: `amp` always lies between 0x0001 and 0x3FFF.
- R6: A write with `wr_en` high stores `wr_data` into a shadow byte. Addresses 0 to 5 hold tuning word bytes, with address 0 as the least significant byte. Address 6 holds the offset low byte and address 7 the offset high byte. Shadow writes change nothing until an update pulse.
- R7: When `update` is high at an edge, both shadows become active at that edge. The angle step changes to the new word one cycle later, with no jump and no clearing of the phase.
- R8: When `core_rst` is high at an edge, `angle` reads 0 and `amp` reads 0x2000 after that edge. The programmed words are kept, so the old frequency resumes without a new update.
- R9: When `rst` is high, all state clears: shadow words, active words, accumulator, `angle` = 0 and `amp` = 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous full reset, active high |
| core_rst | input | 1 | Synchronous reset of the accumulator and the conversion pipeline |
| wr_en | input | 1 | Shadow byte write strobe |
| wr_addr | input | 3 | Shadow byte address (0-5 tuning word, 6-7 offset) |
| wr_data | input | 8 | Shadow byte value |
| update | input | 1 | One-cycle pulse that copies the shadows to the active registers |
| angle | output | 19 | Registered truncated phase |
| amp | output | 14 | Offset-binary sine amplitude |

## Verification
The assertions assume that `rst` is held high from time zero for at least one edge. They also assume that `update` and `core_rst` are single-cycle synchronous pulses, so the active words may only move on an edge where `update` is sampled high. The stimulus changes every input on the falling clock edge and raises `update` only after the shadow writes have ended. It sweeps tuning words that cover every quadrant, the Nyquist step and a negative step. The amplitude is compared against a real-valued sine of the angle observed 20 cycles earlier.

// File: rtl/dds_pkg.sv
package dds_pkg;
    localparam int ACC_W     = 48;
    localparam int ANG_W     = 19;
    localparam int AMP_W     = 14;
    localparam int POFF_W    = 16;
    localparam int Z_W       = 32;
    localparam int GUARD     = 6;
    localparam int DW        = AMP_W + GUARD + 2;
    localparam int STAGES    = 18;
    localparam int LATENCY   = STAGES + 2;
    localparam int AMP_PEAK  = (1 << (AMP_W - 1)) - 1;
    localparam int AMP_MID   = 1 << (AMP_W - 1);
    // start vector pre-scaled by the inverse CORDIC gain (0.607253)
    localparam longint X_INIT = ((longint'(AMP_PEAK) << GUARD) * 64'sd607253) / 64'sd1000000;

    typedef struct packed {
        logic signed [DW-1:0]  x;
        logic signed [DW-1:0]  y;
        logic signed [Z_W-1:0] z;
        logic                  neg;
    } rot_t;

    // arctan(2^-i) with a full turn equal to 2^32
    function automatic logic [Z_W-1:0] atan_step(input int i);
        case (i)
            0:  return 32'h2000_0000;
            1:  return 32'h12E4_051E;
            2:  return 32'h09FB_385B;
            3:  return 32'h0511_11D4;
            4:  return 32'h028B_0D43;
            5:  return 32'h0145_D7E1;
            6:  return 32'h00A2_F61E;
            7:  return 32'h0051_7C55;
            8:  return 32'h0028_BE53;
            9:  return 32'h0014_5F2F;
            10: return 32'h000A_2F98;
            11: return 32'h0005_17CC;
            12: return 32'h0002_8BE6;
            13: return 32'h0001_45F3;
            14: return 32'h0000_A2FA;
            15: return 32'h0000_517D;
            16: return 32'h0000_28BE;
            17: return 32'h0000_145F;
            18: return 32'h0000_0A30;
            19: return 32'h0000_0518;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/dds_word_regs.sv
module dds_word_regs
    import dds_pkg::*;
#(
    parameter int FTW_W = ACC_W,
    parameter int OFF_W = POFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             update,
    output logic [FTW_W-1:0] ftw_act,
    output logic [OFF_W-1:0] off_act
);
    localparam int FTW_BYTES = FTW_W / 8;
    localparam int OFF_BYTES = OFF_W / 8;

    logic [FTW_W-1:0] ftw_sh;
    logic [OFF_W-1:0] off_sh;
    int               sel;

    always_comb sel = int'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw_sh <= '0;
            off_sh <= '0;
        end else if (wr_en) begin
            if (sel < FTW_BYTES)
                ftw_sh[sel*8 +: 8] <= wr_data;
            else if (sel < FTW_BYTES + OFF_BYTES)
                off_sh[(sel-FTW_BYTES)*8 +: 8] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ftw_act <= '0;
            off_act <= '0;
        end else if (update) begin
            ftw_act <= ftw_sh;
            off_act <= off_sh;
        end
    end
endmodule

// File: rtl/dds_phase_path.sv
module dds_phase_path
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic [ACC_W-1:0] ftw,
    input  logic [POFF_W-1:0] off,
    output logic [ANG_W-1:0] angle
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] shifted_sum;

    always_comb shifted_sum = acc + {off, {(ACC_W-POFF_W){1'b0}}};

    always_ff @(posedge clk) begin
        if (clr) begin
            acc   <= '0;
            angle <= '0;
        end else begin
            acc   <= acc + ftw;
            angle <= shifted_sum[ACC_W-1 -: ANG_W];
        end
    end
endmodule

// File: rtl/dds_rot_stage.sv
module dds_rot_stage
    import dds_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic clk,
    input  logic clr,
    input  rot_t d,
    output rot_t q
);
    localparam logic signed [Z_W-1:0] STEP = $signed(atan_step(SHIFT));

    rot_t nxt;

    always_comb begin
        nxt     = d;
        if (!d.z[Z_W-1]) begin
            nxt.x = d.x - (d.y >>> SHIFT);
            nxt.y = d.y + (d.x >>> SHIFT);
            nxt.z = d.z - STEP;
        end else begin
            nxt.x = d.x + (d.y >>> SHIFT);
            nxt.y = d.y - (d.x >>> SHIFT);
            nxt.z = d.z + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/dds_sine_conv.sv
module dds_sine_conv
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic [ANG_W-1:0] angle,
    output logic [AMP_W-1:0] amp
);
    localparam logic signed [DW-1:0] X0   = DW'(X_INIT);
    localparam logic signed [DW-1:0] PK   = DW'(AMP_PEAK);
    localparam logic signed [DW-1:0] HALF = DW'(1 << (GUARD - 1));
    localparam logic signed [DW-1:0] MID  = DW'(AMP_MID);

    rot_t             prep;
    rot_t             stg [0:STAGES];
    logic [Z_W-1:0]   wide;
    logic             fold;
    logic signed [DW-1:0] y_rnd, y_clip, y_sgn, y_out;

    // fold quadrants 2 and 3 onto +/-90 degrees and negate at the end
    always_comb begin
        wide = {angle, {(Z_W-ANG_W){1'b0}}};
        fold = wide[Z_W-1] ^ wide[Z_W-2];
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            prep <= '0;
        end else begin
            prep.x   <= X0;
            prep.y   <= '0;
            prep.z   <= $signed(fold ? (wide ^ {1'b1, {(Z_W-1){1'b0}}}) : wide);
            prep.neg <= fold;
        end
    end

    assign stg[0] = prep;

    for (genvar i = 0; i < STAGES; i++) begin : g_rot
        dds_rot_stage #(.SHIFT(i)) stage_i (
            .clk (clk),
            .clr (clr),
            .d   (stg[i]),
            .q   (stg[i+1])
        );
    end

    always_comb begin
        y_rnd = (stg[STAGES].y + HALF) >>> GUARD;
        if (y_rnd > PK)       y_clip = PK;
        else if (y_rnd < -PK) y_clip = -PK;
        else                  y_clip = y_rnd;
        y_sgn = stg[STAGES].neg ? -y_clip : y_clip;
        y_out = y_sgn + MID;
    end

    always_ff @(posedge clk) begin
        if (clr) amp <= AMP_W'(AMP_MID);
        else     amp <= y_out[AMP_W-1:0];
    end
endmodule

// File: rtl/dds_core.sv
module dds_core
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             core_rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             update,
    output logic [ANG_W-1:0] angle,
    output logic [AMP_W-1:0] amp
);
    logic [ACC_W-1:0]  ftw_act;
    logic [POFF_W-1:0] off_act;
    logic              clr;

    always_comb clr = rst | core_rst;

    dds_word_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .update  (update),
        .ftw_act (ftw_act),
        .off_act (off_act)
    );

    dds_phase_path phase_i (
        .clk   (clk),
        .clr   (clr),
        .ftw   (ftw_act),
        .off   (off_act),
        .angle (angle)
    );

    dds_sine_conv conv_i (
        .clk   (clk),
        .clr   (clr),
        .angle (angle),
        .amp   (amp)
    );
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk
    import dds_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              core_rst,
    input logic              update,
    input logic [ANG_W-1:0]  angle,
    input logic [AMP_W-1:0]  amp,
    input logic [ACC_W-1:0]  ftw_act,
    input logic [POFF_W-1:0] off_act
);
    p_amp_range_r5: assert property (@(posedge clk) disable iff (rst)
        (amp >= AMP_W'(1)) && (amp <= AMP_W'(2*AMP_PEAK + 1)));

    p_act_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !update |=> ($stable(ftw_act) && $stable(off_act)));

    p_core_clear_r8: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> (angle == '0) && (amp == AMP_W'(AMP_MID)));

    p_rst_mid_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (angle == '0) && (amp == AMP_W'(AMP_MID)) && (ftw_act == '0));
endmodule

bind dds_core dds_core_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .core_rst (core_rst),
    .update   (update),
    .angle    (angle),
    .amp      (amp),
    .ftw_act  (ftw_act),
    .off_act  (off_act)
);

// File: tb/dds_core_tb.sv
module dds_core_tb_top;
    localparam int L = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        update = 1'b0;
    logic [18:0] angle;
    logic [13:0] amp;

    int checks = 0;
    int fails  = 0;
    bit run_chk = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dds_core dut_i (
        .clk(clk), .rst(rst), .core_rst(core_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .update(update),
        .angle(angle), .amp(amp)
    );

    // reference model built from the requirements
    logic [47:0] sh_ftw = '0, m_acc, m_ftw;
    logic [15:0] sh_off = '0, m_off;
    logic [18:0] m_ang;
    logic [47:0] m_sum;
    bit          m_rs;

    always_comb m_sum = m_acc + {m_off, 32'h0};

    always @(posedge clk) begin
        m_rs <= rst | core_rst;
        if (rst) begin
            m_acc <= '0; m_ang <= '0; m_ftw <= '0; m_off <= '0;
        end else begin
            if (core_rst) begin
                m_acc <= '0; m_ang <= '0;
            end else begin
                m_acc <= m_acc + m_ftw;
                m_ang <= m_sum[47:29];
            end
            if (update) begin
                m_ftw <= sh_ftw; m_off <= sh_off;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sine_exp(input int a);
        real s;
        s = $sin(2.0 * 3.14159265358979 * real'(a) / 524288.0);
        return 8192 + int'($floor(8191.0 * s + 0.5));
    endfunction

    int hist [64];
    int hidx = 0;

    always @(negedge clk) begin
        if (m_rs) for (int i = 0; i < 64; i++) hist[i] = 0;
        if (run_chk) begin
            int e, d;
            check(angle == m_ang, "R1 R3 angle", angle, m_ang);
            e = sine_exp(hist[(hidx - L) & 63]);
            d = int'(amp) - e;
            check(d <= 2 && d >= -2, "R4 amplitude", amp, e);
            check(amp >= 14'd1 && amp <= 14'h3FFF, "R5 range", amp, 14'h2000);
        end
        hist[hidx & 63] = int'(angle);
        hidx = (hidx + 1) & 63;
    end

    task automatic load(input logic [47:0] f, input logic [15:0] o);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 3'(i);
            wr_data = (i < 6) ? f[i*8 +: 8] : o[(i-6)*8 +: 8];
        end
        @(negedge clk);
        wr_en = 1'b0;
        sh_ftw = f; sh_off = o;
    endtask

    task automatic pulse_update();
        @(negedge clk); update = 1'b1;
        @(negedge clk); update = 1'b0;
    endtask

    task automatic pulse_core();
        @(negedge clk); core_rst = 1'b1;
        @(negedge clk); core_rst = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [18:0] s0, s1, s2;
        idle(3);
        check(angle == 19'd0, "R9 reset angle", angle, 0);
        check(amp == 14'h2000, "R9 reset amp", amp, 14'h2000);
        rst = 1'b0;
        run_chk = 1'b1;
        idle(5);
        check(angle == 19'd0, "R9 idle after reset", angle, 0);

        // full-circle sweep, every quadrant
        load(48'd37 << 29, 16'h0000);
        pulse_update();
        idle(15000);

        // R6: shadow write without update leaves the step unchanged
        load(48'd5 << 29, 16'h0000);
        idle(20);
        @(negedge clk); s0 = angle;
        @(negedge clk); s1 = angle;
        check((s1 - s0) == 19'd37, "R6 shadow ignored", s1 - s0, 37);

        // R7: retune on update, continuous phase
        @(negedge clk); update = 1'b1;
        @(negedge clk); update = 1'b0; s0 = angle;
        @(negedge clk); s1 = angle;
        @(negedge clk); s2 = angle;
        check((s1 - s0) == 19'd37, "R7 old step before change", s1 - s0, 37);
        check((s2 - s1) == 19'd5, "R7 new step no jump", s2 - s1, 5);
        idle(200);

        // R8: core reset keeps the programmed words
        load(48'd37 << 29, 16'h0000);
        pulse_update();
        idle(50);
        pulse_core();
        check(angle == 19'd0, "R8 angle cleared", angle, 0);
        check(amp == 14'h2000, "R8 amp mid", amp, 14'h2000);
        @(negedge clk); s0 = angle;
        @(negedge clk); s1 = angle;
        check((s1 - s0) == 19'd37, "R8 step kept", s1 - s0, 37);
        idle(100);

        // R2: offset alone at +90 and -90 degrees
        load(48'd0, 16'h4000);
        pulse_update();
        pulse_core();
        idle(30);
        check(angle == 19'h20000, "R2 offset 90deg angle", angle, 19'h20000);
        check(amp >= 14'h3FFD, "R2 offset 90deg amp", amp, 14'h3FFF);
        load(48'd0, 16'hC000);
        pulse_update();
        idle(30);
        check(angle == 19'h60000, "R2 offset 270deg angle", angle, 19'h60000);
        check(amp <= 14'd3, "R2 offset 270deg amp", amp, 1);

        // truncation with a word that has low bits set
        load(48'h1234_5678_9ABC, 16'h1357);
        pulse_update();
        idle(3000);

        // R1: Nyquist step wraps the accumulator every two cycles
        load(48'h8000_0000_0000, 16'h0000);
        pulse_update();
        idle(10);
        @(negedge clk); s0 = angle;
        @(negedge clk); s1 = angle;
        check((s1 - s0) == 19'h40000, "R1 nyquist wrap", s1 - s0, 19'h40000);
        idle(100);

        // R1: negative step turns backwards
        load(48'h0 - (48'd3 << 29), 16'h0000);
        pulse_update();
        idle(10);
        @(negedge clk); s0 = angle;
        @(negedge clk); s1 = angle;
        check((s0 - s1) == 19'd3, "R1 reverse step", s0 - s1, 3);
        idle(2000);

        // R9: full reset clears active words
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        idle(40);
        check(angle == 19'd0, "R9 words cleared angle", angle, 0);
        check(amp == 14'h2000, "R9 words cleared amp", amp, 14'h2000);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule